// File: doc/BRIEF.md
# Pipelined binary32-to-int32 converter

This block turns an IEEE 754 single-precision value into a 32-bit two's-complement integer under one of four rounding directions selected per operand. It accepts one operand per clock and returns the integer, together with an invalid flag, a fixed four cycles later. The invalid flag covers NaN, infinity and any magnitude that does not fit in the signed range.

The first stage sorts each operand into a result class. The classes are `CLS_SHIFT` for ordinary values and `CLS_ZERO`, `CLS_PLUS_ONE`, `CLS_MINUS_ONE` and `CLS_OUT_OF_RANGE` for early results. The early classes are decided by boolean rules on sign, exponent, fraction and mode. In the same stage a subtractor forms the right-shift distance as 157 minus the biased exponent.

Operands in `CLS_SHIFT` move through four stages. A sticky-collecting barrel shift comes first, then rounding with a carry-out overflow test, then negation. Every class travels through the same four stages, so results always leave in the order the operands entered. The flow between stages is `CLS_SHIFT` → shift → round → pack. The early classes skip the arithmetic and are resolved in pack.

Top module: `f2i_convert`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly four clock edges, and it is low during and straight after reset. Rounding mode codes: 0 = nearest with ties to even, 1 = toward zero, 2 = toward minus infinity, 3 = toward plus infinity.
- R2: A biased exponent field (bits 30:23) of 158 or more gives `out_int` = 0x80000000 and `out_invalid` = 1. This covers NaN, infinity and ±2^31.
- R3: With magnitude below one, the result is 0 in mode 1, in mode 2 for positive inputs and in mode 3 for negative inputs. Signed zero gives 0 in every mode.
- R4: In mode 0, an exponent field below 126 gives 0, and an exponent field of 126 with zero fraction (±0.5) gives 0. An exponent field of 126 with nonzero fraction gives +1 or -1 by sign.
- R5: A nonzero negative magnitude below one gives -1 in mode 2, and a nonzero positive one gives +1 in mode 3. Subnormal inputs are included.
- R6: Values whose exponent field lies in 127..157 and that are already integers convert exactly in every mode, up to ±2147483520.
- R7: Fractional values in 127..157 round by mode. Mode 0 goes to nearest and breaks ties to the even integer, mode 1 truncates, mode 2 goes down and mode 3 goes up.
- R8: Negative results appear in two's complement, for example -123.0 gives 0xFFFFFF85.
- R9: `out_invalid` is low for every result that lies in range.
- R10: Operands can arrive on consecutive cycles with changing modes, and each result matches its own operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_float | input | 32 | binary32 operand |
| in_rmode | input | 2 | Rounding mode code |
| out_valid | output | 1 | Result strobe |
| out_int | output | 32 | Signed integer result |
| out_invalid | output | 1 | Conversion impossible or overflow |

## Verification
The bench aims at the class borders. These include exponent fields 125, 126, 127, 157 and 158, the exact ±0.5 tie, signed zero and subnormals in the directed modes, and the half-way points 2.5 and 3.5. A wrong tie rule would return 3 or 4 where 2 or 4 is due. A missing zero guard would return -1 for -0.0 under mode 2, and an off-by-one in the exponent limit would either let 2^31 through or flag 2147483520. Seeded random operands cover every mode and are sent back to back against a bench reference model. That model does its arithmetic on the full significand, so a lost sticky bit or a wrong shift distance shows up as a mismatch.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_DOWN      = 2'd2,
        RM_UP        = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        CLS_SHIFT,
        CLS_ZERO,
        CLS_PLUS_ONE,
        CLS_MINUS_ONE,
        CLS_OUT_OF_RANGE
    } cls_e;

    // Decide whether the truncated magnitude must be bumped by one.
    function automatic logic need_increment(
        input rmode_e mode,
        input logic   neg,
        input logic   lsb,
        input logic   guard,
        input logic   rnd,
        input logic   sticky
    );
        logic inexact;
        logic inc;
        inexact = guard | rnd | sticky;
        unique case (mode)
            RM_NEAR_EVEN: inc = guard & (rnd | sticky | lsb);
            RM_TO_ZERO:   inc = 1'b0;
            RM_DOWN:      inc = neg & inexact;
            RM_UP:        inc = ~neg & inexact;
            default:      inc = 1'b0;
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    parameter int SH_W   = $clog2(INT_W)
) (
    input  logic              sign,
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [FRAC_W-1:0] frac_f,
    input  rmode_e            mode,
    output cls_e              cls,
    output logic [SH_W-1:0]   shamt
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] ONE_E   = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] HALF_E  = EXP_W'(BIAS - 1);
    localparam logic [EXP_W-1:0] LIMIT_E = EXP_W'(BIAS + INT_W - 1);
    localparam logic [EXP_W-1:0] BASE_E  = EXP_W'(BIAS + INT_W - 2);

    logic below_one;
    logic below_half;
    logic zero_val;
    logic frac_zero;

    always_comb begin
        below_one  = exp_f < ONE_E;
        below_half = exp_f < HALF_E;
        frac_zero  = (frac_f == '0);
        zero_val   = (exp_f == '0) && frac_zero;
    end

    // Parallel subtractor: distance from the hidden-bit home position.
    always_comb begin
        shamt = SH_W'(BASE_E - exp_f);
    end

    always_comb begin
        if (exp_f >= LIMIT_E) begin
            cls = CLS_OUT_OF_RANGE;
        end else if (!below_one) begin
            cls = CLS_SHIFT;
        end else if (zero_val) begin
            cls = CLS_ZERO;
        end else begin
            unique case (mode)
                RM_NEAR_EVEN: begin
                    if (below_half || frac_zero) cls = CLS_ZERO;
                    else                        cls = sign ? CLS_MINUS_ONE : CLS_PLUS_ONE;
                end
                RM_TO_ZERO: cls = CLS_ZERO;
                RM_DOWN:    cls = sign ? CLS_MINUS_ONE : CLS_ZERO;
                RM_UP:      cls = sign ? CLS_ZERO : CLS_PLUS_ONE;
                default:    cls = CLS_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/f2i_rshift.sv
module f2i_rshift #(
    parameter int W    = 34,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] sh,
    output logic [W-1:0]    dout
);
    logic [SH_W:0][W-1:0] st;

    assign st[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] moved;
        logic         lost;
        assign moved = st[k] >> D;
        assign lost  = |st[k][D-1:0];
        assign st[k+1] = sh[k] ? (moved | {{(W-1){1'b0}}, lost}) : st[k];
    end

    assign dout = st[SH_W];

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
#(
    parameter int MAG_W = 31,
    parameter int GRS_W = 3
) (
    input  rmode_e                   mode,
    input  logic                     neg,
    input  logic [MAG_W+GRS_W-1:0]   vec,
    output logic [MAG_W:0]           mag,
    output logic                     ovf
);
    logic inc;

    always_comb begin
        inc = need_increment(mode, neg, vec[GRS_W], vec[GRS_W-1],
                             vec[GRS_W-2], |vec[GRS_W-3:0]);
        mag = {1'b0, vec[MAG_W+GRS_W-1:GRS_W]} + {{MAG_W{1'b0}}, inc};
        ovf = mag[MAG_W];
    end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    parameter int INT_W  = 32,
    parameter int GRS_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_float,
    input  logic [1:0]              in_rmode,
    output logic                    out_valid,
    output logic [INT_W-1:0]        out_int,
    output logic                    out_invalid
);
    localparam int MAG_W = INT_W - 1;
    localparam int W     = MAG_W + GRS_W;
    localparam int SH_W  = $clog2(INT_W);
    localparam int PAD_W = W - 1 - FRAC_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    // ---------------- stage 1: split and classify ----------------
    logic              c_sign;
    logic [EXP_W-1:0]  c_exp;
    logic [FRAC_W-1:0] c_frac;
    cls_e              c_cls;
    logic [SH_W-1:0]   c_shamt;

    assign c_sign = in_float[EXP_W+FRAC_W];
    assign c_exp  = in_float[EXP_W+FRAC_W-1:FRAC_W];
    assign c_frac = in_float[FRAC_W-1:0];

    f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .SH_W(SH_W)) u_cls (
        .sign   (c_sign),
        .exp_f  (c_exp),
        .frac_f (c_frac),
        .mode   (rmode_e'(in_rmode)),
        .cls    (c_cls),
        .shamt  (c_shamt)
    );

    logic              s1_v, s1_sign;
    cls_e              s1_cls;
    rmode_e            s1_mode;
    logic [SH_W-1:0]   s1_shamt;
    logic [FRAC_W-1:0] s1_frac;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v     <= 1'b0;
            s1_sign  <= 1'b0;
            s1_cls   <= CLS_ZERO;
            s1_mode  <= RM_NEAR_EVEN;
            s1_shamt <= '0;
            s1_frac  <= '0;
        end else begin
            s1_v     <= in_valid;
            s1_sign  <= c_sign;
            s1_cls   <= c_cls;
            s1_mode  <= rmode_e'(in_rmode);
            s1_shamt <= c_shamt;
            s1_frac  <= c_frac;
        end
    end

    // ---------------- stage 2: align and shift ----------------
    logic [W-1:0] aligned;
    logic [W-1:0] shifted;

    // Hidden bit sits at integer bit MAG_W-1 when the shift distance is zero.
    assign aligned = {1'b1, s1_frac, {PAD_W{1'b0}}};

    f2i_rshift #(.W(W), .SH_W(SH_W)) u_shift (
        .din  (aligned),
        .sh   (s1_shamt),
        .dout (shifted)
    );

    logic         s2_v, s2_sign;
    cls_e         s2_cls;
    rmode_e       s2_mode;
    logic [W-1:0] s2_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_sign <= 1'b0;
            s2_cls  <= CLS_ZERO;
            s2_mode <= RM_NEAR_EVEN;
            s2_vec  <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_sign <= s1_sign;
            s2_cls  <= s1_cls;
            s2_mode <= s1_mode;
            s2_vec  <= shifted;
        end
    end

    p_shift_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v && s2_cls == CLS_SHIFT |-> s2_vec != '0);

    // ---------------- stage 3: round ----------------
    logic [MAG_W:0] r_mag;
    logic           r_ovf;

    f2i_round #(.MAG_W(MAG_W), .GRS_W(GRS_W)) u_round (
        .mode (s2_mode),
        .neg  (s2_sign),
        .vec  (s2_vec),
        .mag  (r_mag),
        .ovf  (r_ovf)
    );

    logic           s3_v, s3_sign, s3_ovf;
    cls_e           s3_cls;
    logic [MAG_W:0] s3_mag;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s3_v    <= 1'b0;
            s3_sign <= 1'b0;
            s3_ovf  <= 1'b0;
            s3_cls  <= CLS_ZERO;
            s3_mag  <= '0;
        end else begin
            s3_v    <= s2_v;
            s3_sign <= s2_sign;
            s3_ovf  <= r_ovf;
            s3_cls  <= s2_cls;
            s3_mag  <= r_mag;
        end
    end

    p_round_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s3_v && s3_cls == CLS_SHIFT |->
            (s3_mag == {1'b0, $past(s2_vec[W-1:GRS_W])}) ||
            (s3_mag == {1'b0, $past(s2_vec[W-1:GRS_W])} + 1'b1));

    // ---------------- stage 4: negate and pack ----------------
    logic [INT_W-1:0] p_int;
    logic             p_inv;

    always_comb begin
        p_int = '0;
        p_inv = 1'b0;
        unique case (s3_cls)
            CLS_OUT_OF_RANGE: begin
                p_int = INT_MIN;
                p_inv = 1'b1;
            end
            CLS_ZERO:      p_int = '0;
            CLS_PLUS_ONE:  p_int = {{(INT_W-1){1'b0}}, 1'b1};
            CLS_MINUS_ONE: p_int = '1;
            CLS_SHIFT: begin
                if (s3_ovf) begin
                    p_int = INT_MIN;
                    p_inv = 1'b1;
                end else begin
                    p_int = s3_sign ? (~s3_mag + 1'b1) : s3_mag;
                end
            end
            default: begin
                p_int = '0;
                p_inv = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_int     <= '0;
            out_invalid <= 1'b0;
        end else begin
            out_valid   <= s3_v;
            out_int     <= p_int;
            out_invalid <= p_inv;
        end
    end

    p_in_range_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s3_v && s3_cls != CLS_OUT_OF_RANGE && !s3_ovf |=> !out_invalid);

    // ---------------- port-level properties ----------------
    p_valid_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);

    p_idle_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##4 !out_valid);

    p_big_exp_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_float[EXP_W+FRAC_W-1:FRAC_W] >= EXP_W'(BIAS + INT_W - 1))
            |-> ##4 (out_valid && out_invalid));

    p_invalid_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_invalid |-> out_int == INT_MIN);

    p_zero_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_rmode == 2'd1 &&
        (in_float[EXP_W+FRAC_W-1:FRAC_W] < EXP_W'(BIAS))
            |-> ##4 (out_int == '0));

endmodule

// File: tb/f2i_convert_test.sv
module f2i_convert_test;

    localparam logic [1:0] NE = 2'd0, TZ = 2'd1, DN = 2'd2, UP = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_float;
    logic [1:0]  in_rmode;
    logic        out_valid;
    logic [31:0] out_int;
    logic        out_invalid;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] q_int[$];
    logic        q_inv[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    f2i_convert uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_float(in_float),
        .in_rmode(in_rmode), .out_valid(out_valid), .out_int(out_int),
        .out_invalid(out_invalid)
    );

    // Reference model working on the full significand.
    task automatic ref_conv(input logic [31:0] f, input logic [1:0] m,
                            output logic [31:0] r, output logic inv);
        logic       sgn;
        int         e, ee, sh;
        longint     sig, ip, rem, half, mag;
        logic       gt, eq, nz, inc;
        sgn = f[31];
        e   = int'(f[30:23]);
        inv = 1'b0;
        r   = 32'h0;
        if (e >= 158) begin
            r   = 32'h8000_0000;
            inv = 1'b1;
            return;
        end
        sig = (e != 0) ? (longint'(1) << 23) | longint'(f[22:0]) : longint'(f[22:0]);
        ee  = (e != 0) ? e : 1;
        if (ee >= 150) begin
            ip = sig << (ee - 150); gt = 0; eq = 0; nz = 0;
        end else begin
            sh = 150 - ee;
            if (sh >= 26) begin
                ip = 0; gt = 0; eq = 0; nz = (sig != 0);
            end else begin
                ip   = sig >> sh;
                rem  = sig & ((longint'(1) << sh) - 1);
                half = longint'(1) << (sh - 1);
                gt = rem > half; eq = rem == half; nz = rem != 0;
            end
        end
        case (m)
            NE:      inc = gt | (eq & ip[0]);
            TZ:      inc = 1'b0;
            DN:      inc = sgn & nz;
            default: inc = ~sgn & nz;
        endcase
        mag = ip + longint'(inc);
        if (mag > 64'sd2147483647) begin
            r   = 32'h8000_0000;
            inv = 1'b1;
        end else begin
            r = sgn ? 32'(-mag) : 32'(mag);
        end
    endtask

    task automatic send(input logic [31:0] f, input logic [1:0] m, input string tag);
        logic [31:0] er;
        logic        ei;
        @(negedge clk);
        in_valid = 1'b1;
        in_float = f;
        in_rmode = m;
        ref_conv(f, m, er, ei);
        q_int.push_back(er);
        q_inv.push_back(ei);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_float = $urandom();
        in_rmode = 2'($urandom());
    endtask

    // Result monitor
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            n_tests++;
            if (q_int.size() == 0) begin
                n_fail++;
                $display("FAIL R1: unexpected out_valid, actual 1 expected 0");
            end else begin
                logic [31:0] ei;
                logic        ev;
                string       tg;
                ei = q_int.pop_front();
                ev = q_inv.pop_front();
                tg = q_tag.pop_front();
                if (out_int !== ei || out_invalid !== ev) begin
                    n_fail++;
                    $display("FAIL %s: actual int=%h inv=%b expected int=%h inv=%b",
                             tg, out_int, out_invalid, ei, ev);
                end
            end
        end
    end

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed0;
        seed0    = $urandom(32'd2024);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_float = '0;
        in_rmode = '0;
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_int !== 32'h0 || out_invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: reset state actual v=%b int=%h inv=%b expected 0 0 0",
                     out_valid, out_int, out_invalid);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 out of range
        send(32'h7FC0_0000, NE, "R2"); send(32'hFF80_0000, UP, "R2");
        send(32'h4F00_0000, TZ, "R2"); send(32'hCF00_0000, DN, "R2");
        // R3 toward-zero small magnitudes
        send(32'h3F7F_FFFF, TZ, "R3"); send(32'hBF00_0000, UP, "R3");
        send(32'h8000_0000, DN, "R3"); send(32'h3F00_0000, DN, "R3");
        send(32'h0000_0000, UP, "R3");
        // R4 nearest-even below one
        send(32'h3F00_0000, NE, "R4"); send(32'hBF00_0000, NE, "R4");
        send(32'h3F00_0001, NE, "R4"); send(32'hBF40_0000, NE, "R4");
        send(32'h3E80_0000, NE, "R4");
        // R5 directed small magnitudes
        send(32'h0000_0001, UP, "R5"); send(32'h8000_0001, DN, "R5");
        send(32'h3E80_0000, UP, "R5");
        // R6 exact integers
        for (int m = 0; m < 4; m++) send(32'h3F80_0000, 2'(m), "R6");
        send(32'h4EFF_FFFF, UP, "R6"); send(32'hCEFF_FFFF, DN, "R6");
        send(32'h42F6_0000, NE, "R6");
        // R7 rounding of fractions
        send(32'h4020_0000, NE, "R7"); send(32'h4060_0000, NE, "R7");
        send(32'hC020_0000, DN, "R7"); send(32'hC020_0000, UP, "R7");
        send(32'h4020_0000, UP, "R7"); send(32'h3FE0_0000, TZ, "R7");
        send(32'h3FC0_0001, NE, "R7");
        // R8 negative two's complement
        send(32'hC2F6_0000, NE, "R8"); send(32'hC2F6_0000, TZ, "R8");
        // R9 in-range outputs keep the flag low
        send(32'h4EFF_FFFF, NE, "R9"); send(32'hCEFF_FFFF, UP, "R9");
        idle();

        // R10 seeded random stream, back to back with occasional gaps
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] f;
            f = $urandom();
            if ((i % 4) != 0) f[30:23] = 8'(120 + ($urandom() % 42));
            send(f, 2'($urandom()), "R10");
            if (($urandom() % 8) == 0) idle();
        end
        idle();
        repeat (10) @(negedge clk);
        n_tests++;
        if (q_int.size() != 0) begin
            n_fail++;
            $display("FAIL R1: results missing actual %0d expected 0", q_int.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule